// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial memory. It runs on a fast system clock and samples the bus clock and bus data lines as ordinary inputs. It drives the data line only by pulling it low, through an open-drain enable output. The block finds start and stop conditions on the bus. It accepts an address byte and answers it only when the address is its own. It then either takes a word address followed by write bytes into an internal byte array, or streams bytes out of that array.

A read goes on byte after byte for as long as the master acknowledges each one. When the master declines to acknowledge, the block releases the line and waits for the next start or stop. A single internal word pointer serves both directions and is kept between transactions. A write that sets the pointer, followed by a repeated start and a read, therefore gives a random read. A read issued with no word address resumes at the location where the last access ended.

Top module: `twm_slave`

## Requirements
- R1: While reset is held, `sda_oe` is low and `idle` is high.
- R2: After a start, the first byte is taken MSB first. Bits 7..1 are the device address and bit 0 selects the direction (1 = read, 0 = write). When bits 7..1 equal `DEV_ADDR`, the block pulls SDA low for the whole ninth clock.
- R3: When the address bits do not match, the block gives no acknowledge. It then leaves SDA released until the next start, and `idle` stays low until a stop.
- R4: In a write, every byte after the address byte is acknowledged. The first such byte sets the word pointer to its value modulo `MEM_BYTES`. Each byte after that is stored at the pointer, and the pointer then advances by one.
- R5: In a read, the block sends the byte at the pointer MSB first and advances the pointer. It sends the next byte each time the master pulls SDA low in the ninth clock.
- R6: When the master leaves SDA high in the ninth clock of a read, the block releases SDA. It does not drive SDA again on later clocks until a new start.
- R7: A stop (SDA rising while SCL is high) ends any transfer and raises `idle`. `idle` falls only on a start. While `idle` is high, `sda_oe` is low.
- R8: A repeated start in any phase drops the current transfer and begins a new address byte.
- R9: The word pointer goes from `MEM_BYTES-1` to 0, for reads and for writes.
- R10: The block changes its SDA drive only while SCL is low.
- R11: The pointer survives a stop, so a read with no word address starts where the previous access ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| idle | output | 1 | High in standby: after reset or stop, until the next start |

## Verification
The bench builds the block with `DEV_ADDR` = 7'h52 and `MEM_BYTES` = 64. The small array lets a single burst fill all of it. It also puts the pointer wrap a few bytes from any start point. Random word-address bytes from 0 to 255 then exercise the modulo mapping. Random write bursts and random reads run alongside directed cases for a wrong address, a master that declines to acknowledge, a read that resumes after a stop, and a wrap in each direction.

// File: rtl/twm_pkg.sv
package twm_pkg;

  // protocol phase of the slave
  typedef enum logic [2:0] {
    S_IDLE,   // standby, waiting for a start
    S_RX,     // shifting in a byte from the master
    S_ACK,    // holding or ending the ninth clock after a byte
    S_TX,     // shifting a byte out to the master
    S_MACK,   // sampling the master's answer to a sent byte
    S_HOLD    // deselected or declined, waiting for start or stop
  } twm_state_e;

  // meaning of the byte being handled
  typedef enum logic [1:0] {
    K_DEV,    // address byte
    K_WADR,   // word address of a write
    K_WDAT,   // write data
    K_RD      // read data
  } twm_kind_e;

endpackage

// File: rtl/twm_sync.sv
module twm_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_ns,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LINES = 2;

  logic [1:0]       rst_pipe;
  logic [LINES-1:0] raw;
  logic [LINES-1:0] cur;
  logic [LINES-1:0] prev;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  assign raw = {scl_i, sda_i};

  // two synchronising flops and one history flop per line
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic ff1, ff2, ff3;
    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) begin
        ff1 <= 1'b1;
        ff2 <= 1'b1;
        ff3 <= 1'b1;
      end else begin
        ff1 <= raw[g];
        ff2 <= ff1;
        ff3 <= ff2;
      end
    end
    assign cur[g]  = ff2;
    assign prev[g] = ff3;
  end

  assign sda_s     = cur[0];
  assign scl_rise  =  cur[1] & ~prev[1];
  assign scl_fall  = ~cur[1] &  prev[1];
  // SDA moving while SCL stays high
  assign start_det =  cur[1] &  prev[1] &  prev[0] & ~cur[0];
  assign stop_det  =  cur[1] &  prev[1] & ~prev[0] &  cur[0];

endmodule

// File: rtl/twm_mem.sv
module twm_mem #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/twm_slave.sv
module twm_slave
  import twm_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         MEM_BYTES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic idle
);

  localparam int PTR_W = $clog2(MEM_BYTES);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(MEM_BYTES - 1);
  localparam logic [3:0] BITS = 4'd8;

  logic rst_ns, sda_s, scl_rise, scl_fall, start_det, stop_det;

  twm_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .rst_ns    (rst_ns),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twm_state_e       state_q, state_d;
  twm_kind_e        kind_q,  kind_d;
  logic [3:0]       bitcnt_q, bitcnt_d;
  logic [7:0]       shreg_q, shreg_d;
  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_inc;
  logic             drive_q, drive_d;
  logic             mem_we;
  logic [7:0]       rdata;

  twm_mem #(.DEPTH(MEM_BYTES)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (ptr_q),
    .wdata (shreg_q),
    .raddr (ptr_q),
    .rdata (rdata)
  );

  assign ptr_inc = (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);

  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    ptr_d    = ptr_q;
    drive_d  = drive_q;
    mem_we   = 1'b0;
    if (stop_det) begin
      state_d = S_IDLE;
      drive_d = 1'b0;
    end else if (start_det) begin
      state_d  = S_RX;
      kind_d   = K_DEV;
      bitcnt_d = '0;
      drive_d  = 1'b0;
    end else begin
      unique case (state_q)
        S_RX: begin
          if (scl_rise && bitcnt_q != BITS) begin
            shreg_d  = {shreg_q[6:0], sda_s};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == BITS) begin
            state_d = S_ACK;
            drive_d = 1'b1;
            unique case (kind_q)
              K_DEV: begin
                if (shreg_q[7:1] == DEV_ADDR) begin
                  kind_d = shreg_q[0] ? K_RD : K_WADR;
                end else begin
                  state_d = S_HOLD;
                  drive_d = 1'b0;
                end
              end
              K_WADR: begin
                ptr_d  = PTR_W'(shreg_q);
                kind_d = K_WDAT;
              end
              K_WDAT: begin
                mem_we = 1'b1;
                ptr_d  = ptr_inc;
              end
              default: begin
                state_d = S_HOLD;
                drive_d = 1'b0;
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bitcnt_d = '0;
            if (kind_q == K_RD) begin
              state_d = S_TX;
              shreg_d = rdata;
              ptr_d   = ptr_inc;
              drive_d = ~rdata[7];
            end else begin
              state_d = S_RX;
              drive_d = 1'b0;
            end
          end
        end
        S_TX: begin
          if (scl_rise) begin
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt_q == BITS) begin
              state_d = S_MACK;
              drive_d = 1'b0;
            end else begin
              shreg_d = {shreg_q[6:0], 1'b0};
              drive_d = ~shreg_q[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            // low answer: fetch next byte at the falling edge via S_ACK
            state_d = sda_s ? S_HOLD : S_ACK;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q  <= S_IDLE;
      kind_q   <= K_DEV;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      ptr_q    <= '0;
      drive_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      kind_q   <= kind_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      ptr_q    <= ptr_d;
      drive_q  <= drive_d;
    end
  end

  assign sda_oe = drive_q;
  assign idle   = (state_q == S_IDLE);

endmodule

// File: rtl/twm_slave_chk.sv
module twm_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic idle,
  input logic start_det,
  input logic stop_det
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (idle && !sda_oe);
    end
  end

  assert_quiet_in_standby_R7: assert property (
    @(posedge clk) disable iff (!rst_n) idle |-> !sda_oe);

  assert_standby_on_stop_R7: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(idle) |-> $past(stop_det));

  assert_wake_on_start_R8: assert property (
    @(posedge clk) disable iff (!rst_n) $fell(idle) |-> $past(start_det));

  assert_drive_while_scl_low_R10: assert property (
    @(posedge clk) disable iff (!rst_n) !$stable(sda_oe) |-> !scl_i);

endmodule

bind twm_slave twm_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .idle      (idle),
  .start_det (start_det),
  .stop_det  (stop_det)
);

// File: tb/twm_slave_test.sv
module twm_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;
  localparam int MEMB       = 64;
  localparam logic [6:0] DEV = 7'h52;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe, idle;
  wire  sda_line = m_sda & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [7:0] ref_mem [MEMB];
  int ref_ptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twm_slave #(.DEV_ADDR(DEV), .MEM_BYTES(MEMB)) uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (m_scl),
    .sda_i  (sda_line),
    .sda_oe (sda_oe),
    .idle   (idle)
  );

  function automatic int nxt(int p);
    return (p + 1) % MEMB;
  endfunction

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, 190000);
      report();
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(H);
      m_scl = 1'b1; tick(H);
      m_scl = 1'b0; tick(2);
    end
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(H/2);
    acked = (sda_line == 1'b0);
    tick(H/2);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    logic s1, s2;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      m_scl = 1'b1; tick(H/2);
      s1 = sda_line; tick(H/2 - 1);
      s2 = sda_line; tick(1);
      m_scl = 1'b0; tick(2);
      b[i] = s1;
      chk(s1 == s2, "R10 data stable while SCL high", int'(s2), int'(s1));
    end
    m_sda = ack ? 1'b0 : 1'b1; tick(H);
    m_scl = 1'b1; tick(H);
    m_scl = 1'b0; tick(2);
    m_sda = 1'b1;
  endtask

  task automatic write_burst(int waddr, int len);
    bit a;
    logic [7:0] d;
    bus_start();
    chk(idle == 1'b0, "R7 idle low after start", int'(idle), 0);
    send_byte({DEV, 1'b0}, a);
    chk(a, "R2 address ack", int'(a), 1);
    send_byte(8'(waddr), a);
    chk(a, "R4 word address ack", int'(a), 1);
    ref_ptr = waddr % MEMB;
    for (int i = 0; i < len; i++) begin
      d = 8'($urandom);
      send_byte(d, a);
      chk(a, "R4 data ack", int'(a), 1);
      ref_mem[ref_ptr] = d;
      ref_ptr = nxt(ref_ptr);
    end
    bus_stop();
    chk(idle == 1'b1, "R7 idle after stop", int'(idle), 1);
  endtask

  task automatic read_run(int len, string req);
    bit a;
    logic [7:0] d;
    send_byte({DEV, 1'b1}, a);
    chk(a, "R2 read address ack", int'(a), 1);
    for (int i = 0; i < len; i++) begin
      recv_byte(i < len - 1, d);
      chk(d == ref_mem[ref_ptr], req, int'(d), int'(ref_mem[ref_ptr]));
      ref_ptr = nxt(ref_ptr);
    end
    bus_stop();
    chk(idle == 1'b1, "R7 idle after read stop", int'(idle), 1);
  endtask

  task automatic read_at(int waddr, int len, string req);
    bit a;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    chk(a, "R2 address ack", int'(a), 1);
    send_byte(8'(waddr), a);
    chk(a, "R4 word address ack", int'(a), 1);
    ref_ptr = waddr % MEMB;
    bus_start();  // repeated start, R8
    read_run(len, req);
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    void'($urandom(32'd1234));
    #1 rst_n = 1'b0;
    tick(5);
    chk(sda_oe == 1'b0, "R1 sda_oe in reset", int'(sda_oe), 0);
    chk(idle == 1'b1, "R1 idle in reset", int'(idle), 1);
    rst_n = 1'b1;
    tick(5);

    // fill the whole array, ending on a wrap back to 0 (R4, R9)
    write_burst(0, MEMB);
    read_at(0, 6, "R5 read after fill");

    // pointer wrap on write and on read (R9)
    write_burst(MEMB - 2, 4);
    read_at(MEMB - 3, 5, "R9 read across wrap");

    // read resumes after stop with no word address (R11)
    read_at(10, 2, "R5 read before resume");
    bus_start();
    read_run(3, "R11 current address read");

    // wrong device address (R3)
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a);
    chk(!a, "R3 no ack on mismatch", int'(a), 0);
    send_byte(8'h00, a);
    chk(!a, "R3 no ack after mismatch", int'(a), 0);
    chk(idle == 1'b0, "R3 idle low until stop", int'(idle), 0);
    bus_stop();
    chk(idle == 1'b1, "R7 idle after stop", int'(idle), 1);

    // master declines: no further drive (R6)
    read_at(20, 1, "R5 single byte read");
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, d);
    chk(d == ref_mem[ref_ptr], "R5 byte before decline", int'(d), int'(ref_mem[ref_ptr]));
    ref_ptr = nxt(ref_ptr);
    recv_byte(1'b0, d);
    chk(d == 8'hFF, "R6 released after decline", int'(d), 8'hFF);
    bus_stop();

    // repeated start in the middle of a write leaves memory unchanged (R8)
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'd30, a);
    bus_start();
    send_byte({DEV, 1'b0}, a);
    chk(a, "R8 address ack after repeated start", int'(a), 1);
    send_byte(8'd30, a);
    bus_stop();
    read_at(30, 1, "R8 data kept after aborted write");

    // constrained random mix (R4, R5, R9)
    for (int it = 0; it < 20; it++) begin
      int adr, len;
      adr = int'($urandom % 256);
      len = 1 + int'($urandom % 6);
      if ($urandom % 2 == 0) write_burst(adr, len);
      else                   read_at(adr, len, "R5 random read");
    end

    report();
  end

endmodule